// File: doc/BRIEF.md
# DMA Interrupt Flag Register

This block is the interrupt control and status register of a multi-channel DMA engine. It holds one interrupt enable per channel, a master enable, a force bit that also stands for a bus error, a small field of low control bits that are stored and read back, and one completion flag per channel. Each channel signals the end of a transfer with a one-cycle pulse. The flag of that channel is set if its enable is on. Software clears flags by writing a 1 to them.

A summary bit in the top position is computed by the block and cannot be written. It is set when the force bit is on, or when the master enable is on and at least one completion flag is set. A single-cycle request pulse goes to the system interrupt controller only when this summary bit changes from clear to set. Further completions while it is already set send no new request. Once software clears the condition, the next completion raises a fresh request.

Top module: `dmairq_flag_reg`

## Requirements
- R1: While reset is held (synchronous, active low), the register reads 0x00000000 and the request output is low.
- R2: A write loads bits 0 to 5 (low control field), bit 15 (force), bits 16 to 22 (per-channel enables, channel n at bit 16+n) and bit 23 (master enable) from the written data. Bits 6 to 14 always read 0.
- R3: On a write, each completion flag in bits 24 to 30 (channel n at bit 24+n) is cleared where the written bit is 1 and kept where it is 0. With no write and no completion pulse, the register does not change.
- R4: A completion pulse on channel n sets bit 24+n only if enable bit 16+n was set before that clock edge. If a pulse and a write clearing the same flag arrive together, the flag ends up set.
- R5: Bit 31 equals (bit 23 AND any of bits 24 to 30) OR bit 15. It is re-evaluated after every update, and the value written to bit 31 has no effect.
- R6: The request output is high for exactly the one cycle after the edge at which bit 31 changes from 0 to 1. It stays low while bit 31 remains set.
- R7: After bit 31 has returned to 0, a later rise of bit 31 produces a new request pulse.
- R8: Clearing an enable bit or the master enable leaves the completion flags that are already set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| done_i | input | NUM_CH (7) | Per-channel completion pulses |
| rd_data | output | 32 | Current register contents, including the summary bit |
| irq_pulse_o | output | 1 | One-cycle interrupt request to the system controller |

## Verification
The bench applies inputs on the falling edge, and every effect shows up one rising edge later. Register contents, the summary bit and the request pulse all come from registers that are loaded at that same edge, so there is no extra cycle of delay. The bench therefore compares rd_data and irq_pulse_o at the next falling edge with a model value. That value is built from the register contents before the edge and the inputs that were applied. The directed steps also check literal values at that same falling edge. A missing or repeated request would show up as a mismatch in the exact cycle after the summary bit rises.

// File: rtl/dmairq_pkg.sv
// Package: bit positions and widths of the DMA interrupt flag register.
// Assumes a 32-bit register with at most seven DMA channels.
package dmairq_pkg;
    localparam int REG_W     = 32;
    localparam int MAX_CH    = 7;
    localparam int LOW_W     = 6;
    localparam int FORCE_BIT = 15;
    localparam int EN_LSB    = 16;
    localparam int MEN_BIT   = 23;
    localparam int FLAG_LSB  = 24;
    localparam int SUM_BIT   = 31;

    // Stored control fields, grouped for passing between modules
    typedef struct packed {
        logic             master_en;
        logic [MAX_CH-1:0] chan_en;
        logic             force_irq;
        logic [LOW_W-1:0] low_bits;
    } ctrl_t;
endpackage

// File: rtl/dmairq_ctrl_fields.sv
// Module: holds the directly writable control fields (low bits, force,
// per-channel enables, master enable). Assumes a write replaces every
// field at once; unused enable positions above NUM_CH stay zero.
module dmairq_ctrl_fields
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_d
);
    ctrl_t written;

    // Extract the control fields from the write data
    always_comb begin
        written           = '0;
        written.low_bits  = wr_data[LOW_W-1:0];
        written.force_irq = wr_data[FORCE_BIT];
        written.chan_en[NUM_CH-1:0] = wr_data[EN_LSB +: NUM_CH];
        written.master_en = wr_data[MEN_BIT];
    end

    // Select the next control value: written fields or held value
    always_comb begin
        ctrl_d = wr_en ? written : ctrl_q;
    end

    // Store the control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/dmairq_flag_bank.sv
// Module: one completion flag per channel, write-1-to-clear, set by a
// completion pulse gated by the channel's enable as stored before the
// edge. A set in the same cycle as a clear wins.
module dmairq_flag_bank
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] chan_en_q,
    output logic [NUM_CH-1:0] flags_q,
    output logic [NUM_CH-1:0] flags_d
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
        logic clr_hit;
        logic set_hit;

        // Decode the clear and set events for this channel
        always_comb begin
            clr_hit = wr_en && clr_bits[ch];
            set_hit = done_i[ch] && chan_en_q[ch];
            flags_d[ch] = set_hit || (flags_q[ch] && !clr_hit);
        end

        // Hold the flag of this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[ch] <= 1'b0;
            end else begin
                flags_q[ch] <= flags_d[ch];
            end
        end
    end
endmodule

// File: rtl/dmairq_master_eval.sv
// Module: recomputes the summary bit from the next field values and
// emits a one-cycle request when the summary bit goes from 0 to 1.
// Assumes inputs are the values that will be registered at this edge.
module dmairq_master_eval #(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en_d,
    input  logic              force_d,
    input  logic [NUM_CH-1:0] flags_d,
    output logic              summary_q,
    output logic              req_q
);
    logic summary_d;

    // Summary term from the fields about to be stored
    always_comb begin
        summary_d = (master_en_d && (|flags_d)) || force_d;
    end

    // Register the summary bit and the rising-edge request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            summary_q <= 1'b0;
            req_q     <= 1'b0;
        end else begin
            summary_q <= summary_d;
            req_q     <= summary_d && !summary_q;
        end
    end
endmodule

// File: rtl/dmairq_flag_reg.sv
// Top: DMA interrupt flag register. Combines the control fields, the
// flag bank and the summary evaluator into one 32-bit readable word.
// Assumes NUM_CH is between 1 and 7; the write port has no address.
module dmairq_flag_reg
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [NUM_CH-1:0] done_i,
    output logic [31:0]       rd_data,
    output logic              irq_pulse_o
);
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_d;
    logic [NUM_CH-1:0] flags_q;
    logic [NUM_CH-1:0] flags_d;
    logic              summary_q;
    logic              unused_wr;

    // Bits 6..14 and 31 of the write data carry no state
    assign unused_wr = ^wr_data;

    dmairq_ctrl_fields #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .ctrl_d  (ctrl_d)
    );

    dmairq_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .clr_bits  (wr_data[FLAG_LSB +: NUM_CH]),
        .done_i    (done_i),
        .chan_en_q (ctrl_q.chan_en[NUM_CH-1:0]),
        .flags_q   (flags_q),
        .flags_d   (flags_d)
    );

    dmairq_master_eval #(.NUM_CH(NUM_CH)) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en_d (ctrl_d.master_en),
        .force_d     (ctrl_d.force_irq),
        .flags_d     (flags_d),
        .summary_q   (summary_q),
        .req_q       (irq_pulse_o)
    );

    // Assemble the readable word from the stored fields
    always_comb begin
        rd_data                       = '0;
        rd_data[LOW_W-1:0]            = ctrl_q.low_bits;
        rd_data[FORCE_BIT]            = ctrl_q.force_irq;
        rd_data[EN_LSB +: NUM_CH]     = ctrl_q.chan_en[NUM_CH-1:0];
        rd_data[MEN_BIT]              = ctrl_q.master_en;
        rd_data[FLAG_LSB +: NUM_CH]   = flags_q;
        rd_data[SUM_BIT]              = summary_q;
    end
endmodule

// File: rtl/dmairq_flag_reg_chk.sv
// Checker: temporal properties of the DMA interrupt flag register,
// observed at the top-level ports only. Bound to every instance.
module dmairq_flag_reg_chk #(
    parameter int NUM_CH = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [NUM_CH-1:0] done_i,
    input logic [31:0]       rd_data,
    input logic              irq_pulse_o
);
    logic past_ok;

    // Marks that one clean cycle after reset has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 32'h0 && !irq_pulse_o));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!wr_en && done_i == '0) |=> $stable(rd_data));

    assert_gated_set_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        1'b1 |=> ((rd_data[24 +: NUM_CH] & ~$past(rd_data[24 +: NUM_CH])
                   & ~$past(rd_data[16 +: NUM_CH])) == '0));

    assert_summary_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rd_data[31] == ((rd_data[23] && (|rd_data[30:24])) || rd_data[15]));

    assert_pulse_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        irq_pulse_o |-> (rd_data[31] && !$past(rd_data[31])));

    assert_rise_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $rose(rd_data[31]) |-> irq_pulse_o);

    assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[14:6] == 9'h0);
endmodule

bind dmairq_flag_reg dmairq_flag_reg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .done_i      (done_i),
    .rd_data     (rd_data),
    .irq_pulse_o (irq_pulse_o)
);

// File: tb/dmairq_flag_reg_tb.sv
module dmairq_flag_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [31:0]    wr_data = '0;
    logic [NCH-1:0] done_i = '0;
    logic [31:0]    rd_data;
    logic           irq_pulse_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model = '0;
    logic        model_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmairq_flag_reg #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done_i(done_i), .rd_data(rd_data), .irq_pulse_o(irq_pulse_o)
    );

    // Next register value built from the requirement text
    function automatic logic [31:0] next_reg(logic [31:0] cur, logic we,
                                             logic [31:0] wd, logic [NCH-1:0] dn);
        logic [31:0] ctl;
        logic [6:0]  fl;
        logic        sm;
        ctl = we ? (wd & 32'h00FF803F) : (cur & 32'h00FF803F);
        fl  = cur[30:24];
        if (we) fl = fl & ~wd[30:24];
        fl  = fl | (dn & cur[22:16]);
        sm  = (ctl[23] && (fl != 0)) || ctl[15];
        return {sm, fl, ctl[23:0]};
    endfunction

    task automatic check(string tag, logic [31:0] exp_rd, logic exp_irq);
        checks++;
        if (rd_data !== exp_rd || irq_pulse_o !== exp_irq) begin
            failures++;
            $display("FAIL %s: rd_data=%08h irq=%0b expected rd_data=%08h irq=%0b",
                     tag, rd_data, irq_pulse_o, exp_rd, exp_irq);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, advance the model
    task automatic step(logic we, logic [31:0] wd, logic [NCH-1:0] dn);
        wr_en = we;
        wr_data = wd;
        done_i = dn;
        model_irq = 1'b0;
        begin
            logic [31:0] nx;
            nx = next_reg(model, we, wd, dn);
            model_irq = nx[31] && !model[31];
            model = nx;
        end
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        done_i = '0;
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'h0, 1'b0);

        step(1'b1, 32'hFFFFFFFF, '0);
        check("R2 R5 R6 all-ones write", 32'h80FF803F, 1'b1);
        step(1'b0, 32'h0, '0);
        check("R6 single cycle pulse", 32'h80FF803F, 1'b0);
        step(1'b1, 32'h80FF0000, '0);
        check("R5 bit31 not writable", 32'h00FF0000, 1'b0);
        step(1'b0, 32'h0, 7'b0000101);
        check("R4 R6 completion raises", 32'h85FF0000, 1'b1);
        step(1'b0, 32'h0, 7'b0000010);
        check("R6 no pulse while set", 32'h87FF0000, 1'b0);
        step(1'b1, 32'h01FF0000, '0);
        check("R3 clear one flag", 32'h86FF0000, 1'b0);
        step(1'b1, 32'h06FF0000, '0);
        check("R3 R5 clear all flags", 32'h00FF0000, 1'b0);
        step(1'b1, 32'h00F70000, '0);
        step(1'b0, 32'h0, 7'b0001000);
        check("R4 disabled channel ignored", 32'h00F70000, 1'b0);
        step(1'b0, 32'h0, 7'b0000100);
        check("R7 new pulse after fall", 32'h84F70000, 1'b1);
        step(1'b1, 32'h04F70000, 7'b0000100);
        check("R4 set wins over clear", 32'h84F70000, 1'b0);
        step(1'b1, 32'h00770000, '0);
        check("R5 R8 master enable off keeps flags", 32'h04770000, 1'b0);
        step(1'b1, 32'h00000000, '0);
        check("R8 enables off keep flags", 32'h04000000, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic        we;
            logic [31:0] wd;
            logic [NCH-1:0] dn;
            we = ($urandom % 4) == 0;
            wd = $urandom;
            if (($urandom % 3) == 0) wd[31:24] = 8'h00;
            dn = ($urandom % 2) ? NCH'($urandom) : '0;
            step(we, wd, dn);
            check("R2 R3 R4 R5 R6 R7 R8 random", model, model_irq);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule